// File: doc/BRIEF.md
# Truth-Table Programmable Multifunction ALU

A combinational integer ALU for a general-purpose datapath. Two N-bit operands, a carry/borrow input and a 5-bit operation select produce an N-bit result and four flags. The logic half is a bank of per-bit 4-to-1 multiplexers. A 4-bit truth-table code is the data input of each multiplexer, and the operand bit pair is its select, so any of the sixteen two-input Boolean functions can be chosen.

The arithmetic half conditions the operands and then feeds one two's-complement ripple-carry chain of full adders. This gives add, add with carry, subtract, subtract with borrow, reverse subtract (plain and with borrow), negate A or B, and increment or decrement of A or B. A final 2-to-1 multiplexer, steered by the top select bit, picks the logic or the arithmetic result.

Top module: `tt_alu`

## Requirements
- R1: With op_i[4]=0, each result bit i equals bit k of the code op_i[3:0], where k = {a_i[i], b_i[i]} (a_i bit is the upper select bit).
- R2: Logic codes (op_i[3:0]): 0000 zero, 1111 all ones, 1000 AND, 1110 OR, 0110 XOR, 1001 XNOR, 0111 NAND, 0001 NOR, 1100 pass A, 0011 NOT A, 1010 pass B, 0101 NOT B.
- R3: For any logic operation, cout_o and ovf_o are 0.
- R4: op_i=10000 gives A+B, and 10001 gives A+B+cin_i. cout_o is the carry out of bit N-1.
- R5: op_i=10010 gives A-B, and 10011 gives A-B-cin_i (cin_i acts as borrow). cout_o is 1 when no borrow occurs.
- R6: op_i=10100 gives B-A, and 10101 gives B-A-cin_i, with the same carry meaning as R5.
- R7: op_i=10110 gives -A and 10111 gives -B. cout_o is the carry of 0 + ~X + 1.
- R8: op_i=11000 gives A+1, 11001 gives B+1, 11010 gives A-1 (A + all ones), 11011 gives B-1. cout_o is the adder carry.
- R9: Arithmetic opcodes 11100 to 11111 give a zero result, with cout_o=0 and ovf_o=0.
- R10: zero_o is 1 exactly when every result bit is 0.
- R11: neg_o equals res_o[N-1].
- R12: For arithmetic operations, ovf_o is 1 exactly when the signed two's-complement sum of the conditioned operands overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | N | Operand A |
| b_i | input | N | Operand B |
| cin_i | input | 1 | Carry in, or borrow in for the borrow variants |
| op_i | input | 5 | Bit 4: 0 selects logic, 1 selects arithmetic. Bits 3:0: truth-table code or arithmetic opcode |
| res_o | output | N | Result |
| cout_o | output | 1 | Adder carry out (0 for logic operations) |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Result MSB |
| ovf_o | output | 1 | Signed overflow (0 for logic operations) |

## Verification
A fixed vector table runs each logic code on one mixed bit pattern, so every truth-table position is exercised and swapped code bits are exposed. The arithmetic opcodes are run on operands picked to push the chain to the sign boundary (7F+1, 80-1-borrow, negating 80), which separates the carry meaning from the overflow meaning. All sixteen codes and all opcodes are then crossed with the operands 00, FF, 80 and 7F, which catches faults in the carry-in polarity and in the borrow inversion. Random operands are compared against a behavioural model to cover the middle of the ripple chain.

// File: rtl/tt_alu_pkg.sv
package tt_alu_pkg;
  localparam int OP_W   = 5;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    AR_ADD  = 4'd0,
    AR_ADC  = 4'd1,
    AR_SUB  = 4'd2,
    AR_SBB  = 4'd3,
    AR_RSB  = 4'd4,
    AR_RSBB = 4'd5,
    AR_NEGA = 4'd6,
    AR_NEGB = 4'd7,
    AR_INCA = 4'd8,
    AR_INCB = 4'd9,
    AR_DECA = 4'd10,
    AR_DECB = 4'd11
  } arith_op_e;
endpackage

// File: rtl/tt_logic_unit.sv
module tt_logic_unit #(
  parameter int N = 8
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [3:0]   code_i,
  output logic [N-1:0] res_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    // operand bits form the select; the code supplies the truth table
    assign res_o[i] = code_i[{a_i[i], b_i[i]}];
  end
endmodule

// File: rtl/tt_operand_cond.sv
module tt_operand_cond
  import tt_alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]      a_i,
  input  logic [N-1:0]      b_i,
  input  logic              cin_i,
  input  logic [CODE_W-1:0] opc_i,
  output logic [N-1:0]      x_o,
  output logic [N-1:0]      y_o,
  output logic              c_o
);
  always_comb begin
    x_o = '0;
    y_o = '0;
    c_o = 1'b0;
    case (opc_i)
      AR_ADD:  begin x_o = a_i; y_o = b_i; end
      AR_ADC:  begin x_o = a_i; y_o = b_i;  c_o = cin_i;  end
      AR_SUB:  begin x_o = a_i; y_o = ~b_i; c_o = 1'b1;   end
      AR_SBB:  begin x_o = a_i; y_o = ~b_i; c_o = ~cin_i; end
      AR_RSB:  begin x_o = b_i; y_o = ~a_i; c_o = 1'b1;   end
      AR_RSBB: begin x_o = b_i; y_o = ~a_i; c_o = ~cin_i; end
      AR_NEGA: begin y_o = ~a_i; c_o = 1'b1; end
      AR_NEGB: begin y_o = ~b_i; c_o = 1'b1; end
      AR_INCA: begin x_o = a_i; c_o = 1'b1; end
      AR_INCB: begin x_o = b_i; c_o = 1'b1; end
      AR_DECA: begin x_o = a_i; y_o = '1; end
      AR_DECB: begin x_o = b_i; y_o = '1; end
      default: ;  // unused opcodes: 0 + 0 + 0
    endcase
  end
endmodule

// File: rtl/tt_ripple_adder.sv
module tt_ripple_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         c_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);
  logic [N:0] cy;
  assign cy[0] = c_i;

  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum_o[i] = x_i[i] ^ y_i[i] ^ cy[i];
    assign cy[i+1]  = (x_i[i] & y_i[i]) | (x_i[i] & cy[i]) | (y_i[i] & cy[i]);
  end

  assign cout_o = cy[N];
  assign cmsb_o = cy[N-1];
endmodule

// File: rtl/tt_alu.sv
module tt_alu
  import tt_alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]    a_i,
  input  logic [N-1:0]    b_i,
  input  logic            cin_i,
  input  logic [OP_W-1:0] op_i,
  output logic [N-1:0]    res_o,
  output logic            cout_o,
  output logic            zero_o,
  output logic            neg_o,
  output logic            ovf_o
);
  localparam int SEL_BIT = OP_W - 1;

  logic [N-1:0] logic_res, x, y, sum;
  logic         c_in, c_out, c_msb, is_arith;

  assign is_arith = op_i[SEL_BIT];

  tt_logic_unit #(.N(N)) u_logic (
    .a_i(a_i), .b_i(b_i), .code_i(op_i[CODE_W-1:0]), .res_o(logic_res)
  );

  tt_operand_cond #(.N(N)) u_cond (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .opc_i(op_i[CODE_W-1:0]),
    .x_o(x), .y_o(y), .c_o(c_in)
  );

  tt_ripple_adder #(.N(N)) u_add (
    .x_i(x), .y_i(y), .c_i(c_in), .sum_o(sum), .cout_o(c_out), .cmsb_o(c_msb)
  );

  assign res_o  = is_arith ? sum : logic_res;
  assign cout_o = is_arith & c_out;
  assign ovf_o  = is_arith & (c_out ^ c_msb);
  assign zero_o = ~|res_o;
  assign neg_o  = res_o[N-1];
endmodule

// File: rtl/tt_alu_chk.sv
module tt_alu_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         cin_i,
  input logic [4:0]   op_i,
  input logic [N-1:0] res_o,
  input logic         cout_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         ovf_o
);
  logic unused_cin;
  assign unused_cin = cin_i;

  always_comb begin
    a_r10_zero_flag: assert (zero_o == (res_o == '0));
    a_r11_neg_flag:  assert (neg_o == res_o[N-1]);
    if (!op_i[4]) begin
      a_r3_logic_flags: assert (!cout_o && !ovf_o);
    end
    if (op_i == 5'b01000) begin
      a_r2_and: assert (res_o == (a_i & b_i));
    end
    if (op_i == 5'b10000) begin
      a_r4_add: assert ({cout_o, res_o} == ({1'b0, a_i} + {1'b0, b_i}));
    end
    if (op_i[4] && (op_i[3:2] == 2'b11)) begin
      a_r9_unused: assert ((res_o == '0) && !cout_o && !ovf_o);
    end
  end
endmodule

bind tt_alu tt_alu_chk #(.N(N)) u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .op_i(op_i), .res_o(res_o),
  .cout_o(cout_o), .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o)
);

// File: tb/tt_alu_test.sv
module tt_alu_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [N-1:0] a, b, res;
  logic         cin, cout, zero, neg, ovf;
  logic [4:0]   op;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  tt_alu #(.N(N)) uut (
    .a_i(a), .b_i(b), .cin_i(cin), .op_i(op), .res_o(res),
    .cout_o(cout), .zero_o(zero), .neg_o(neg), .ovf_o(ovf)
  );

  // {op, a, b, cin, exp_res, exp_cout, exp_ovf}
  localparam int NV = 21;
  localparam logic [31:0] VEC [NV] = '{
    {5'b01000, 8'hCA, 8'hA5, 1'b0, 8'h80, 1'b0, 1'b0},
    {5'b01110, 8'hCA, 8'hA5, 1'b0, 8'hEF, 1'b0, 1'b0},
    {5'b00110, 8'hCA, 8'hA5, 1'b0, 8'h6F, 1'b0, 1'b0},
    {5'b01001, 8'hCA, 8'hA5, 1'b1, 8'h90, 1'b0, 1'b0},
    {5'b00111, 8'hCA, 8'hA5, 1'b0, 8'h7F, 1'b0, 1'b0},
    {5'b00001, 8'hCA, 8'hA5, 1'b0, 8'h10, 1'b0, 1'b0},
    {5'b00011, 8'hCA, 8'hA5, 1'b0, 8'h35, 1'b0, 1'b0},
    {5'b01010, 8'hCA, 8'hA5, 1'b1, 8'hA5, 1'b0, 1'b0},
    {5'b10000, 8'h7F, 8'h01, 1'b1, 8'h80, 1'b0, 1'b1},
    {5'b10001, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0},
    {5'b10010, 8'h05, 8'h07, 1'b0, 8'hFE, 1'b0, 1'b0},
    {5'b10011, 8'h80, 8'h01, 1'b1, 8'h7E, 1'b1, 1'b1},
    {5'b10100, 8'h03, 8'h10, 1'b0, 8'h0D, 1'b1, 1'b0},
    {5'b10101, 8'h01, 8'h01, 1'b0, 8'h00, 1'b1, 1'b0},
    {5'b10110, 8'h80, 8'h33, 1'b0, 8'h80, 1'b0, 1'b1},
    {5'b10111, 8'h12, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0},
    {5'b11000, 8'h7F, 8'h00, 1'b0, 8'h80, 1'b0, 1'b1},
    {5'b11001, 8'h00, 8'hFF, 1'b0, 8'h00, 1'b1, 1'b0},
    {5'b11010, 8'h00, 8'h44, 1'b0, 8'hFF, 1'b0, 1'b0},
    {5'b11011, 8'h55, 8'h80, 1'b0, 8'h7F, 1'b1, 1'b1},
    {5'b11110, 8'hFF, 8'hFF, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  function automatic string req_of(logic [4:0] o);
    if (!o[4]) return "R2";
    case (o[3:0])
      4'd0, 4'd1:  return "R4";
      4'd2, 4'd3:  return "R5";
      4'd4, 4'd5:  return "R6";
      4'd6, 4'd7:  return "R7";
      4'd8, 4'd9, 4'd10, 4'd11: return "R8";
      default:     return "R9";
    endcase
  endfunction

  // behavioural model: returns {cout, res, ovf}
  function automatic logic [N+1:0] model(logic [4:0] o, logic [N-1:0] av,
                                         logic [N-1:0] bv, logic ci);
    logic [N-1:0] x = '0, y = '0, r;
    logic c = 1'b0;
    logic [N:0] s;
    if (!o[4]) begin
      for (int i = 0; i < N; i++) r[i] = o[{av[i], bv[i]}];  // R1
      return {1'b0, r, 1'b0};
    end
    case (o[3:0])
      4'd0:  begin x = av; y = bv; end
      4'd1:  begin x = av; y = bv; c = ci; end
      4'd2:  begin x = av; y = ~bv; c = 1'b1; end
      4'd3:  begin x = av; y = ~bv; c = ~ci; end
      4'd4:  begin x = bv; y = ~av; c = 1'b1; end
      4'd5:  begin x = bv; y = ~av; c = ~ci; end
      4'd6:  begin y = ~av; c = 1'b1; end
      4'd7:  begin y = ~bv; c = 1'b1; end
      4'd8:  begin x = av; c = 1'b1; end
      4'd9:  begin x = bv; c = 1'b1; end
      4'd10: begin x = av; y = '1; end
      4'd11: begin x = bv; y = '1; end
      default: ;
    endcase
    s = {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c};
    return {s[N], s[N-1:0], (x[N-1] == y[N-1]) && (s[N-1] != x[N-1])};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: op=%b a=%h b=%h cin=%b actual %h expected %h",
               tag, op, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(logic [4:0] o, logic [N-1:0] av, logic [N-1:0] bv, logic ci);
    @(negedge clk);
    op = o; a = av; b = bv; cin = ci;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(logic [N+1:0] e);
    logic [N-1:0] er = e[N:1];
    check(req_of(op), {23'd0, res}, {23'd0, er});
    if (!op[4]) check("R3", {30'd0, cout, ovf}, 32'd0);
    else begin
      check("R4", {31'd0, cout}, {31'd0, e[N+1]});
      check("R12", {31'd0, ovf}, {31'd0, e[0]});
    end
    check("R10", {31'd0, zero}, {31'd0, (er == '0)});
    check("R11", {31'd0, neg}, {31'd0, er[N-1]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    op = '0; a = '0; b = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    // initial state: code 0000 gives zero result
    check("R2", {23'd0, res}, 32'd0);
    check("R10", {31'd0, zero}, 32'd1);
    check("R3", {30'd0, cout, ovf}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      logic [31:0] v = VEC[k];
      apply(v[31:27], v[26:19], v[18:11], v[10]);
      check(req_of(op), {23'd0, res}, {23'd0, v[9:2]});
      check(op[4] ? "R12" : "R3", {30'd0, cout, ovf}, {30'd0, v[1:0]});
      check("R10", {31'd0, zero}, {31'd0, (v[9:2] == 8'h00)});
      check("R11", {31'd0, neg}, {31'd0, v[9]});
    end

    // corner operands crossed with every select value (R1, R9 included)
    for (int o = 0; o < 32; o++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          for (int c = 0; c < 2; c++) begin
            logic [N-1:0] cs [4] = '{8'h00, 8'hFF, 8'h80, 8'h7F};
            apply(o[4:0], cs[i], cs[j], c[0]);
            check_all(model(o[4:0], cs[i], cs[j], c[0]));
          end
        end
      end
    end

    // random operands, R1 per-bit mux and arithmetic chain
    for (int k = 0; k < 1500; k++) begin
      logic [4:0] o = 5'($urandom);
      logic [N-1:0] av = N'($urandom), bv = N'($urandom);
      logic ci = 1'($urandom);
      apply(o, av, bv, ci);
      check_all(model(o, av, bv, ci));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule